// File: doc/BRIEF.md
# Reaction Trial Sequencer

This block is the control state machine for a single reaction-time trial at an interactive exhibit. It watches a clean, active-high button level and the countdown status of a slow random-delay timer. It commands three neighbours: a millisecond counter (clear and run), the random-delay timer (start), and a light-pattern multiplexer (a two-bit select). All decisions are paced by a one-clock strobe that arrives once per millisecond. Between strobes the state and every command output stay frozen.

A trial moves through five named states:

- `ST_IDLE`: shows the attract pattern and leaves the last measurement on display.
- `ST_READY`: entered on a press. It clears the counter and shows the slow pattern while the button stays down.
- `ST_ARM`: entered on release. It raises the start request and holds it until the delay timer's expired flag falls.
- `ST_WAIT`: the countdown is running.
- `ST_TIMING`: entered when the expired flag rises again. It shows the fast pattern and runs the counter.

The named transitions are:

- idle-press: `ST_IDLE` to `ST_READY`.
- release: `ST_READY` to `ST_ARM`.
- handshake: `ST_ARM` to `ST_WAIT`.
- go: `ST_WAIT` to `ST_TIMING`.
- early-press: `ST_ARM` or `ST_WAIT` to `ST_READY`.
- stop: `ST_TIMING` to `ST_IDLE`.

Only the stop transition produces the one-clock measurement-done pulse that the best-time recorder uses. A separate best-time clear request is passed through one register to the recorder.

Top module: `reaction_sequencer`

## Requirements
- R1: A synchronous reset puts the machine in `ST_IDLE`. On the next clock, clear, run, start and done are low, and the pattern select is 2'b01 (attract).
- R2: State and the clear, run, start and select outputs change only on a clock edge where `ms_tick` is high. The outputs of a state appear one clock after the ticked edge.
- R3: In `ST_IDLE`, a ticked press enters `ST_READY`. `tmr_clear` goes high and the select becomes 2'b00 (slow). Without a press, idle keeps `tmr_clear` low, so the last time is kept.
- R4: In `ST_READY`, a ticked release enters `ST_ARM`. `rnd_start` is high there, and stays high on every tick while `rnd_expired` stays high.
- R5: In `ST_ARM` with the button up, a tick that sees `rnd_expired` low enters `ST_WAIT`. `rnd_start` drops and the select stays slow.
- R6: In `ST_ARM` or `ST_WAIT`, a ticked press returns the machine to `ST_READY`. This takes priority over the expired flag.
- R7: In `ST_WAIT`, a tick that sees `rnd_expired` high with the button up enters `ST_TIMING`. `tmr_run` goes high, the select becomes 2'b10 (fast), and `tmr_clear` is low.
- R8: In `ST_TIMING`, a ticked press enters `ST_IDLE`. `tmr_run` drops and `meas_done` is high for exactly one clock, in that same clock.
- R9: `meas_done` is never raised for any other exit from timing. A reset taken while timing yields no done pulse.
- R10: `best_clear` equals `best_rst` delayed by one clock, regardless of tick or state. It can coincide with `meas_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-clock strobe per millisecond that paces decisions |
| btn | input | 1 | Debounced button level, high while pressed |
| rnd_expired | input | 1 | Random-delay timer at zero |
| best_rst | input | 1 | Request to clear the best-time record |
| tmr_clear | output | 1 | Clear the millisecond counter |
| tmr_run | output | 1 | Let the millisecond counter advance |
| rnd_start | output | 1 | Load and start the random-delay timer |
| pat_sel | output | SEL_W | Light pattern: 00 slow, 01 attract, 10 fast |
| meas_done | output | 1 | One-clock pulse when a press stops the timing |
| best_clear | output | 1 | Registered best-time clear to the recorder |

## Verification
The stop transition's done pulse and the pass-through of a best-time clear can land in the same clock. The bench provokes this by raising `best_rst` in the very clock whose tick carries the stopping press. It then expects `meas_done` and `best_clear` both high one clock later, with the machine idle. A second overlap is covered by a sweep over every state and every button/expired pair. That sweep checks that a press and a rising expired flag in the same tick resolve in favour of the press.

// File: rtl/rt_pkg.sv
package rt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READY  = 3'd1,
        ST_ARM    = 3'd2,
        ST_WAIT   = 3'd3,
        ST_TIMING = 3'd4
    } rt_state_e;

endpackage

// File: rtl/rt_next_state.sv
module rt_next_state
    import rt_pkg::*;
(
    input  rt_state_e state,
    input  logic      tick,
    input  logic      btn,
    input  logic      expired,
    output rt_state_e nxt,
    output logic      stop_hit
);

    always_comb begin
        nxt      = state;
        stop_hit = 1'b0;
        if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (btn) nxt = ST_READY;
                end
                ST_READY: begin
                    if (!btn) nxt = ST_ARM;
                end
                ST_ARM: begin
                    // early press outranks the handshake
                    if (btn)           nxt = ST_READY;
                    else if (!expired) nxt = ST_WAIT;
                end
                ST_WAIT: begin
                    if (btn)          nxt = ST_READY;
                    else if (expired) nxt = ST_TIMING;
                end
                ST_TIMING: begin
                    if (btn) begin
                        nxt      = ST_IDLE;
                        stop_hit = 1'b1;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rt_out_reg.sv
module rt_out_reg
    import rt_pkg::*;
#(
    parameter int                   SEL_W       = 2,
    parameter logic [SEL_W-1:0]     PAT_SLOW    = 0,
    parameter logic [SEL_W-1:0]     PAT_ATTRACT = 1,
    parameter logic [SEL_W-1:0]     PAT_FAST    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  rt_state_e        nxt,
    input  logic             stop_hit,
    input  logic             best_rst,
    output logic             tmr_clear,
    output logic             tmr_run,
    output logic             rnd_start,
    output logic [SEL_W-1:0] pat_sel,
    output logic             meas_done,
    output logic             best_clear
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_clear  <= 1'b0;
            tmr_run    <= 1'b0;
            rnd_start  <= 1'b0;
            pat_sel    <= PAT_ATTRACT;
            meas_done  <= 1'b0;
            best_clear <= 1'b0;
        end else begin
            meas_done  <= stop_hit;
            best_clear <= best_rst;
            tmr_clear  <= 1'b0;
            tmr_run    <= 1'b0;
            rnd_start  <= 1'b0;
            unique case (nxt)
                ST_IDLE: begin
                    pat_sel <= PAT_ATTRACT;
                end
                ST_READY: begin
                    tmr_clear <= 1'b1;
                    pat_sel   <= PAT_SLOW;
                end
                ST_ARM: begin
                    rnd_start <= 1'b1;
                    pat_sel   <= PAT_SLOW;
                end
                ST_WAIT: begin
                    pat_sel <= PAT_SLOW;
                end
                ST_TIMING: begin
                    tmr_run <= 1'b1;
                    pat_sel <= PAT_FAST;
                end
                default: pat_sel <= PAT_ATTRACT;
            endcase
        end
    end

endmodule

// File: rtl/reaction_sequencer.sv
module reaction_sequencer
    import rt_pkg::*;
#(
    parameter int               SEL_W       = 2,
    parameter logic [SEL_W-1:0] PAT_SLOW    = 0,
    parameter logic [SEL_W-1:0] PAT_ATTRACT = 1,
    parameter logic [SEL_W-1:0] PAT_FAST    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ms_tick,
    input  logic             btn,
    input  logic             rnd_expired,
    input  logic             best_rst,
    output logic             tmr_clear,
    output logic             tmr_run,
    output logic             rnd_start,
    output logic [SEL_W-1:0] pat_sel,
    output logic             meas_done,
    output logic             best_clear
);

    rt_state_e state_q;
    rt_state_e state_nxt;
    logic      stop_hit;

    rt_next_state i_next (
        .state    (state_q),
        .tick     (ms_tick),
        .btn      (btn),
        .expired  (rnd_expired),
        .nxt      (state_nxt),
        .stop_hit (stop_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nxt;
    end

    rt_out_reg #(
        .SEL_W       (SEL_W),
        .PAT_SLOW    (PAT_SLOW),
        .PAT_ATTRACT (PAT_ATTRACT),
        .PAT_FAST    (PAT_FAST)
    ) i_out (
        .clk        (clk),
        .rst        (rst),
        .nxt        (state_nxt),
        .stop_hit   (stop_hit),
        .best_rst   (best_rst),
        .tmr_clear  (tmr_clear),
        .tmr_run    (tmr_run),
        .rnd_start  (rnd_start),
        .pat_sel    (pat_sel),
        .meas_done  (meas_done),
        .best_clear (best_clear)
    );

endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
    parameter int               SEL_W       = 2,
    parameter logic [SEL_W-1:0] PAT_SLOW    = 0,
    parameter logic [SEL_W-1:0] PAT_ATTRACT = 1,
    parameter logic [SEL_W-1:0] PAT_FAST    = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             ms_tick,
    input logic             btn,
    input logic             rnd_expired,
    input logic             best_rst,
    input logic             tmr_clear,
    input logic             tmr_run,
    input logic             rnd_start,
    input logic [SEL_W-1:0] pat_sel,
    input logic             meas_done,
    input logic             best_clear
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!tmr_clear && !tmr_run && !rnd_start && !meas_done && pat_sel == PAT_ATTRACT));

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !ms_tick |=> ($stable(tmr_clear) && $stable(tmr_run) && $stable(rnd_start) && $stable(pat_sel)));

    assert_start_slow_R4: assert property (@(posedge clk) disable iff (rst)
        rnd_start |-> (pat_sel == PAT_SLOW && !tmr_run && !tmr_clear));

    assert_run_fast_R7: assert property (@(posedge clk) disable iff (rst)
        tmr_run |-> (pat_sel == PAT_FAST && !tmr_clear));

    assert_go_on_expired_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(tmr_run) |-> $past(rnd_expired) && $past(!btn));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        meas_done |=> !meas_done);

    assert_done_after_run_R9: assert property (@(posedge clk) disable iff (rst)
        meas_done |-> ($past(tmr_run) && !tmr_run));

    assert_best_follow_R10: assert property (@(posedge clk) disable iff (rst)
        best_rst |=> best_clear);

    assert_best_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !best_rst |=> !best_clear);

endmodule

bind reaction_sequencer rt_checker #(
    .SEL_W       (SEL_W),
    .PAT_SLOW    (PAT_SLOW),
    .PAT_ATTRACT (PAT_ATTRACT),
    .PAT_FAST    (PAT_FAST)
) i_rt_checker (
    .clk         (clk),
    .rst         (rst),
    .ms_tick     (ms_tick),
    .btn         (btn),
    .rnd_expired (rnd_expired),
    .best_rst    (best_rst),
    .tmr_clear   (tmr_clear),
    .tmr_run     (tmr_run),
    .rnd_start   (rnd_start),
    .pat_sel     (pat_sel),
    .meas_done   (meas_done),
    .best_clear  (best_clear)
);

// File: tb/test_reaction_sequencer.sv
`timescale 1ns/1ps
module test_reaction_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ms_tick = 1'b0;
    logic       btn = 1'b0;
    logic       rnd_expired = 1'b1;
    logic       best_rst = 1'b0;
    logic       tmr_clear, tmr_run, rnd_start, meas_done, best_clear;
    logic [1:0] pat_sel;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    reaction_sequencer i_reaction_sequencer (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .btn(btn),
        .rnd_expired(rnd_expired), .best_rst(best_rst),
        .tmr_clear(tmr_clear), .tmr_run(tmr_run), .rnd_start(rnd_start),
        .pat_sel(pat_sel), .meas_done(meas_done), .best_clear(best_clear)
    );

    // bench state numbering: 0 idle, 1 ready, 2 arm, 3 wait, 4 timing
    function automatic int model_next(int s, bit b, bit e);
        case (s)
            0: return b ? 1 : 0;
            1: return b ? 1 : 2;
            2: return b ? 1 : (e ? 2 : 3);
            3: return b ? 1 : (e ? 4 : 3);
            default: return b ? 0 : 4;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(string req, int s);
        check({req, " clear"}, int'(tmr_clear), int'(s == 1));
        check({req, " start"}, int'(rnd_start), int'(s == 2));
        check({req, " run"},   int'(tmr_run),   int'(s == 4));
        check({req, " sel"},   int'(pat_sel),   (s == 0) ? 1 : ((s == 4) ? 2 : 0));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ms_tick = 1'b0; btn = 1'b0; rnd_expired = 1'b1; best_rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic tick();
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic go_to(int s);
        do_reset();
        if (s >= 1) begin btn = 1'b1; tick(); end
        if (s >= 2) begin btn = 1'b0; tick(); end
        if (s >= 3) begin rnd_expired = 1'b0; tick(); end
        if (s >= 4) begin rnd_expired = 1'b1; tick(); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        do_reset();
        check("R1 done", int'(meas_done), 0);
        check_state("R1", 0);

        // R2: press held without tick changes nothing
        btn = 1'b1;
        repeat (5) @(negedge clk);
        check_state("R2 no-tick", 0);
        tick();
        check_state("R2/R3 ticked press", 1);
        repeat (3) @(negedge clk);
        check_state("R2 hold ready", 1);

        // R4: start held while expired stays high
        btn = 1'b0; rnd_expired = 1'b1;
        tick();
        for (int k = 0; k < 4; k++) begin
            tick();
            check_state("R4 start held", 2);
        end
        rnd_expired = 1'b0;
        tick();
        check_state("R5 handshake", 3);

        // sweep: every state x every button/expired pair (R3..R8, R6 priority)
        for (int s = 0; s < 5; s++) begin
            for (int c = 0; c < 4; c++) begin
                bit b = c[1];
                bit e = c[0];
                int n;
                go_to(s);
                btn = b; rnd_expired = e;
                tick();
                n = model_next(s, b, e);
                check_state($sformatf("R6/R7 sweep s%0d b%0d e%0d", s, b, e), n);
                check($sformatf("R8 done s%0d b%0d e%0d", s, b, e),
                      int'(meas_done), int'(s == 4 && b));
                @(negedge clk);
                check("R8 done one clock", int'(meas_done), 0);
            end
        end

        // R9: reset while timing yields no done
        go_to(4);
        rst = 1'b1;
        @(negedge clk);
        check("R9 no done on reset", int'(meas_done), 0);
        check("R9 run dropped", int'(tmr_run), 0);
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R9 still no done", int'(meas_done), 0);
        end

        // R10: best clear follows input, no tick
        best_rst = 1'b1;
        @(negedge clk);
        best_rst = 1'b0;
        check("R10 best clear", int'(best_clear), 1);
        @(negedge clk);
        check("R10 best clear drop", int'(best_clear), 0);

        // R10 + R8 collision: stop press and best clear in the same clock
        go_to(4);
        btn = 1'b1; best_rst = 1'b1;
        tick();
        best_rst = 1'b0;
        check("R8 collide done", int'(meas_done), 1);
        check("R10 collide clear", int'(best_clear), 1);
        check_state("R8 collide idle", 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule